// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Timer Pin Override

This block is a general-purpose I/O port controller for a bank of eight pins. Software reaches four byte-wide registers over a simple synchronous register bus. The bus has an address, a write strobe, write data and a combinational read-data output. The four registers hold the output latch, the pin directions, the pullup enables and the slew enables. Toward the pads the block drives, for each pin, an output-enable, an output value, a pullup request and a slew request. It also samples each pad level through a two-flop synchronizer.

Any pin can be claimed by a timer channel. A claimed pin follows the timer's mode and ignores its direction bit. In compare mode the pin is an output that carries the timer's value. In capture mode the pin is an input. The pullup and slew requests depend on who owns the pin and on the timer mode. Reading the data register returns the output latch for pins set as outputs and the synchronized pad level for pins set as inputs.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset, all four registers read 0 and all four pad control outputs (`pad_oe`, `pad_out`, `pad_pullup`, `pad_slew`) are 0.
- R2: A write with `bus_wr_en` high stores `bus_wr_data` at the rising edge. The offsets are 0 for data, 1 for pullup enable, 2 for slew enable and 3 for direction. Each register reads back what was written.
- R3: For a pin whose direction bit is 1, bit n of a read at offset 0 returns the output latch bit.
- R4: For a pin whose direction bit is 0, bit n of a read at offset 0 returns the pad level through two flops. A change applied between edges is not visible after the first rising edge and is visible after the second.
- R5: For a pin the timer does not own, `pad_oe` equals the direction bit and `pad_out` equals the output latch bit.
- R6: For a pin the timer does not own, `pad_pullup` is the pullup bit AND NOT the direction bit, and `pad_slew` is the slew bit AND the direction bit. `pad_oe` and `pad_pullup` are never both 1 on any pin.
- R7: For a pin with `tmr_own`=1 and `tmr_cmp_mode`=1 (compare mode), `pad_oe` is 1 and `pad_out` equals `tmr_out`, whatever the direction bit and the latch. `pad_slew` equals the slew bit and `pad_pullup` is 0.
- R8: For a pin with `tmr_own`=1 and `tmr_cmp_mode`=0 (capture mode), `pad_oe`, `pad_out` and `pad_slew` are 0, and `pad_pullup` is the pullup bit AND NOT the direction bit.
- R9: Offsets 4 to 7 read as 0. Writes to them change no register.
- R10: A write to offset 0 updates the output latch even while the pin is an input. When the direction bit is then set, `pad_out` and the read value show the preloaded level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_oe | output | 8 | Output driver enable per pin |
| pad_out | output | 8 | Output value per pin |
| pad_pullup | output | 8 | Pullup request per pin |
| pad_slew | output | 8 | Slew control request per pin |
| tmr_own | input | 8 | Timer owns the pin |
| tmr_cmp_mode | input | 8 | 1 = compare (output), 0 = capture (input) |
| tmr_out | input | 8 | Timer drive value for compare mode |

## Verification
The pad outputs are tried with the same register contents under three ownership patterns: no timer ownership, ownership in compare mode, and ownership in capture mode. This separates the direction-following path from each override path. The read path is tried with mixed direction masks, with a latch value that differs from the pad value, and with a pad change sampled one edge and then two edges after it is applied. These cases separate latch readback from pin readback and show the synchronizer depth. Preloading the latch while the pins are inputs, writing to the unmapped offsets and a mid-run reset check that the stored state is kept apart from the bus and pad behaviour.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_PULL = 2'd1,
        SEL_SLEW = 2'd2,
        SEL_DIR  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_ovr_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [WIDTH-1:0]  bus_wr_data,
    output logic [WIDTH-1:0]  bus_rd_data,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  latch_val,
    output logic [WIDTH-1:0]  pull_val,
    output logic [WIDTH-1:0]  slew_val,
    output logic [WIDTH-1:0]  dir_val
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] pull;
        logic [WIDTH-1:0] slew;
        logic [WIDTH-1:0] dir;
    } port_regs_t;

    port_regs_t regs_d, regs_q;
    logic       mapped;
    reg_sel_e   sel;

    generate
        if (ADDR_W > SEL_W) begin : g_wide
            assign mapped = (bus_addr[ADDR_W-1:SEL_W] == '0);
        end else begin : g_narrow
            assign mapped = 1'b1;
        end
    endgenerate

    assign sel = reg_sel_e'(bus_addr[SEL_W-1:0]);

    always_comb begin
        regs_d = regs_q;
        if (bus_wr_en && mapped) begin
            unique case (sel)
                SEL_DATA: regs_d.latch = bus_wr_data;
                SEL_PULL: regs_d.pull  = bus_wr_data;
                SEL_SLEW: regs_d.slew  = bus_wr_data;
                SEL_DIR:  regs_d.dir   = bus_wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rd_data = '0;
        if (mapped) begin
            unique case (sel)
                SEL_DATA: bus_rd_data = (regs_q.latch & regs_q.dir) | (pin_sync & ~regs_q.dir);
                SEL_PULL: bus_rd_data = regs_q.pull;
                SEL_SLEW: bus_rd_data = regs_q.slew;
                SEL_DIR:  bus_rd_data = regs_q.dir;
            endcase
        end
    end

    assign latch_val = regs_q.latch;
    assign pull_val  = regs_q.pull;
    assign slew_val  = regs_q.slew;
    assign dir_val   = regs_q.dir;

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_val,
    input  logic [WIDTH-1:0] pull_val,
    input  logic [WIDTH-1:0] slew_val,
    input  logic [WIDTH-1:0] dir_val,
    input  logic [WIDTH-1:0] tmr_own,
    input  logic [WIDTH-1:0] tmr_cmp_mode,
    input  logic [WIDTH-1:0] tmr_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pullup,
    output logic [WIDTH-1:0] pad_slew
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        always_comb begin
            if (tmr_own[p] && tmr_cmp_mode[p]) begin
                pad_oe[p]     = 1'b1;
                pad_out[p]    = tmr_out[p];
                pad_pullup[p] = 1'b0;
                pad_slew[p]   = slew_val[p];
            end else if (tmr_own[p]) begin
                pad_oe[p]     = 1'b0;
                pad_out[p]    = 1'b0;
                pad_pullup[p] = pull_val[p] & ~dir_val[p];
                pad_slew[p]   = 1'b0;
            end else begin
                pad_oe[p]     = dir_val[p];
                pad_out[p]    = latch_val[p];
                pad_pullup[p] = pull_val[p] & ~dir_val[p];
                pad_slew[p]   = slew_val[p] & dir_val[p];
            end
        end
    end

endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
    parameter int NPINS       = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [NPINS-1:0]  bus_wr_data,
    output logic [NPINS-1:0]  bus_rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pullup,
    output logic [NPINS-1:0]  pad_slew,
    input  logic [NPINS-1:0]  tmr_own,
    input  logic [NPINS-1:0]  tmr_cmp_mode,
    input  logic [NPINS-1:0]  tmr_out
);

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] latch_val, pull_val, slew_val, dir_val;

    gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_regfile #(.WIDTH(NPINS), .ADDR_W(ADDR_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .pin_sync    (pin_sync),
        .latch_val   (latch_val),
        .pull_val    (pull_val),
        .slew_val    (slew_val),
        .dir_val     (dir_val)
    );

    gpio_pad_ctrl #(.WIDTH(NPINS)) i_pads (
        .latch_val    (latch_val),
        .pull_val     (pull_val),
        .slew_val     (slew_val),
        .dir_val      (dir_val),
        .tmr_own      (tmr_own),
        .tmr_cmp_mode (tmr_cmp_mode),
        .tmr_out      (tmr_out),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pad_pullup   (pad_pullup),
        .pad_slew     (pad_slew)
    );

endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [NPINS-1:0]  bus_wr_data,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_pullup,
    input logic [NPINS-1:0]  tmr_own,
    input logic [NPINS-1:0]  tmr_cmp_mode,
    input logic [NPINS-1:0]  tmr_out,
    input logic [NPINS-1:0]  latch_val,
    input logic [NPINS-1:0]  pull_val,
    input logic [NPINS-1:0]  slew_val,
    input logic [NPINS-1:0]  dir_val
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_val == '0 && pull_val == '0 && slew_val == '0 && dir_val == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(3)) |=> (dir_val == $past(bus_wr_data)));

    // R6
    no_drive_and_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pullup) == '0);

    // R7
    cmp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_own & tmr_cmp_mode & ~pad_oe) == '0) &&
        (((pad_out ^ tmr_out) & tmr_own & tmr_cmp_mode) == '0));

    // R8
    cap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_own & ~tmr_cmp_mode & pad_oe) == '0) &&
        ((tmr_own & ~tmr_cmp_mode & dir_val & pad_pullup) == '0));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr[ADDR_W-1:2] != '0) |=>
        ($stable(latch_val) && $stable(pull_val) && $stable(slew_val) && $stable(dir_val)));

endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_wr_data  (bus_wr_data),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pad_pullup   (pad_pullup),
    .tmr_own      (tmr_own),
    .tmr_cmp_mode (tmr_cmp_mode),
    .tmr_out      (tmr_out),
    .latch_val    (latch_val),
    .pull_val     (pull_val),
    .slew_val     (slew_val),
    .dir_val      (dir_val)
);

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wr_data = '0;
    logic [7:0] bus_rd_data;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pullup, pad_slew;
    logic [7:0] tmr_own = '0, tmr_cmp_mode = '0, tmr_out = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpio_port_ovr i_gpio_port_ovr (
        .clk, .rst_n, .bus_addr, .bus_wr_en, .bus_wr_data, .bus_rd_data,
        .pad_in, .pad_oe, .pad_out, .pad_pullup, .pad_slew,
        .tmr_own, .tmr_cmp_mode, .tmr_out
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            bus_read(3'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 8'h00);
        end
        chk("R1", "pad_oe", pad_oe, 8'h00);
        chk("R1", "pad_out", pad_out, 8'h00);
        chk("R1", "pad_pullup", pad_pullup, 8'h00);
        chk("R1", "pad_slew", pad_slew, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        bus_write(3'd1, 8'h96);
        bus_write(3'd2, 8'h3C);
        bus_write(3'd3, 8'hFF);
        bus_write(3'd0, 8'hA1);
        bus_read(3'd1, v); chk("R2", "pullup readback", v, 8'h96);
        bus_read(3'd2, v); chk("R2", "slew readback", v, 8'h3C);
        bus_read(3'd3, v); chk("R2", "dir readback", v, 8'hFF);
        bus_read(3'd0, v); chk("R3", "data with all outputs", v, 8'hA1);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        bus_write(3'd3, 8'h00);
        @(negedge clk);
        pad_in = 8'h5E;
        @(negedge clk);
        @(negedge clk);
        pad_in = 8'hA5;
        @(negedge clk);
        bus_read(3'd0, v); chk("R4", "one edge after pad change", v, 8'h5E);
        @(negedge clk);
        bus_read(3'd0, v); chk("R4", "two edges after pad change", v, 8'hA5);
        bus_write(3'd0, 8'h33);
        bus_write(3'd3, 8'h0F);
        bus_read(3'd0, v); chk("R3", "mixed direction read", v, 8'hA3);
    endtask

    task automatic setup_pads(input logic [7:0] dir);
        bus_write(3'd0, 8'h5A);
        bus_write(3'd1, 8'hFF);
        bus_write(3'd2, 8'hCC);
        bus_write(3'd3, dir);
    endtask

    task automatic t_unowned();
        tmr_own = 8'h00;
        setup_pads(8'hF0);
        chk("R5", "unowned oe", pad_oe, 8'hF0);
        chk("R5", "unowned out", pad_out, 8'h5A);
        chk("R6", "unowned pullup", pad_pullup, 8'h0F);
        chk("R6", "unowned slew", pad_slew, 8'hC0);
    endtask

    task automatic t_cmp();
        setup_pads(8'hF0);
        @(negedge clk);
        tmr_own = 8'h0F; tmr_cmp_mode = 8'h0F; tmr_out = 8'h09;
        #1;
        chk("R7", "compare oe", pad_oe, 8'hFF);
        chk("R7", "compare out", pad_out, 8'h59);
        chk("R7", "compare pullup", pad_pullup, 8'h00);
        chk("R7", "compare slew", pad_slew, 8'hCC);
        tmr_out = 8'h06;
        #1;
        chk("R7", "compare out follows timer", pad_out, 8'h56);
    endtask

    task automatic t_cap();
        @(negedge clk);
        tmr_own = 8'h0F; tmr_cmp_mode = 8'h00; tmr_out = 8'hFF;
        setup_pads(8'hF5);
        chk("R8", "capture oe", pad_oe, 8'hF0);
        chk("R8", "capture out", pad_out, 8'h50);
        chk("R8", "capture pullup", pad_pullup, 8'h0A);
        chk("R8", "capture slew", pad_slew, 8'hC0);
        @(negedge clk);
        tmr_own = 8'h00; tmr_out = 8'h00;
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        setup_pads(8'h81);
        bus_write(3'd4, 8'hFF);
        bus_write(3'd5, 8'h00);
        bus_write(3'd7, 8'h42);
        for (int a = 4; a < 8; a++) begin
            bus_read(3'(a), v);
            chk("R9", $sformatf("unmapped offset %0d", a), v, 8'h00);
        end
        bus_read(3'd1, v); chk("R9", "pullup kept", v, 8'hFF);
        bus_read(3'd2, v); chk("R9", "slew kept", v, 8'hCC);
        bus_read(3'd3, v); chk("R9", "dir kept", v, 8'h81);
        chk("R9", "latch kept", pad_out, 8'h5A);
    endtask

    task automatic t_preload();
        logic [7:0] v;
        bus_write(3'd3, 8'h00);
        @(negedge clk);
        pad_in = 8'h00;
        bus_write(3'd0, 8'h3C);
        @(negedge clk);
        bus_read(3'd0, v); chk("R10", "input read shows pins", v, 8'h00);
        chk("R10", "no drive while input", pad_oe, 8'h00);
        bus_write(3'd3, 8'hFF);
        chk("R10", "preloaded level driven", pad_out, 8'h3C);
        bus_read(3'd0, v); chk("R10", "preloaded level read", v, 8'h3C);
    endtask

    task automatic t_midreset();
        setup_pads(8'hFF);
        do_reset();
        #1;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_sync();
        t_unowned();
        t_cmp();
        t_cap();
        t_unmapped();
        t_preload();
        t_midreset();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule